// File: doc/BRIEF.md
# Gated Interrupt Enable Controller

This block gathers event pulses from the rest of a host controller into a sticky status register and turns them into one level interrupt request toward the host bus. Each status bit pairs with the enable bit at the same position. A request is raised only when a status bit and its enable are both 1 and a master enable bit in the top position of the enable register is also 1. The request output is registered.

Software reaches the block through a small word-wide register port with a combinational read path. Address 0 holds the event status, which is acknowledged by writing ones. Address 1 is the enable-set port, where ones set enables and zeros leave them alone. Address 2 is the enable-clear port, where ones clear enables. Both enable addresses read back the same enable word. Address 3 reads as zero and ignores writes. Per-event enables cannot be dropped through the set port. They are removed only through the separate clear port.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset, the enable word, the status word and `irq_o` are all 0.
- R2: A write to address 1 sets every implemented enable bit written as 1 and leaves every bit written as 0 unchanged, visible on the next cycle.
- R3: A write to address 2 clears every enable bit written as 1 and leaves bits written as 0 unchanged.
- R4: Implemented enable bits are 0..6, 30 and 31 (mask 0xC000007F). Bit 31 is the master enable. Bits 7..29 ignore writes and always read 0. Status bits are 0..6 and 30 (mask 0x4000007F), so status bit 31 and the bits in 7..29 always read 0.
- R5: Addresses 1 and 2 return the same current enable word. Address 3 reads 0 and a write there changes nothing.
- R6: A one-cycle pulse on `evt_i[k]`, where k is a status bit, sets status bit k on the next cycle. Pulses on other positions have no effect.
- R7: A write to address 0 clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R8: If an event pulse and an acknowledge hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq_o` is 1 exactly one cycle after a state in which enable bit 31 is 1 and some status bit and its enable are both 1. Otherwise it is 0 one cycle later.
- R10: The master enable alone, or a matching status/enable pair without the master enable, keeps `irq_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 status ack, 1 enable set, 2 enable clear, 3 unused |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same decoding as write |
| rd_data | output | 32 | Combinational read data |
| evt_i | input | 32 | One-cycle event pulses, one per status position |
| irq_o | output | 1 | Registered level interrupt request |

## Verification
Register writes and event pulses take effect at the next rising edge. The bench therefore drives them at a falling edge and reads back through the combinational read port at the following falling edge. The interrupt output carries one more register. The bench records the gating condition from its own model state before each edge and compares `irq_o` against that value after the edge, on every cycle of the run. Sweeps walk a single one across all 32 positions of each write port and the event input, and the expected words come from fixed masks.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

   localparam int unsigned REG_W   = 32;
   localparam int unsigned SEL_W   = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_STATUS = 2'd0,
      SEL_EN_SET = 2'd1,
      SEL_EN_CLR = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;

   // Enable mask = event positions plus the master position
   function automatic logic [REG_W-1:0] en_mask_f(input logic [REG_W-1:0] evt_mask,
                                                  input int unsigned master_bit);
      logic [REG_W-1:0] m;
      m = evt_mask;
      m[master_bit] = 1'b1;
      return m;
   endfunction

   // Status mask = event positions with the master position forced out
   function automatic logic [REG_W-1:0] st_mask_f(input logic [REG_W-1:0] evt_mask,
                                                  input int unsigned master_bit);
      logic [REG_W-1:0] m;
      m = evt_mask;
      m[master_bit] = 1'b0;
      return m;
   endfunction

endpackage

// File: rtl/irq_en_bank.sv
module irq_en_bank #(
   parameter int unsigned          W    = 32,
   parameter logic [W-1:0]         MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] en_q
);

   logic [W-1:0] set_v;
   logic [W-1:0] clr_v;
   logic [W-1:0] en_d;

   always_comb begin
      set_v = set_we ? (wdata & MASK) : '0;
      clr_v = clr_we ? (wdata & MASK) : '0;
      en_d  = ((en_q | set_v) & ~clr_v) & MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_d;
   end

endmodule

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
   parameter int unsigned          W    = 32,
   parameter logic [W-1:0]         MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         ack_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] st_q
);

   logic [W-1:0] hit_v;
   logic [W-1:0] ack_v;
   logic [W-1:0] st_d;

   always_comb begin
      hit_v = evt & MASK;
      ack_v = ack_we ? (wdata & MASK) : '0;
      // an event in the same cycle overrides the acknowledge
      st_d  = (st_q & ~ack_v) | hit_v;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
   parameter int unsigned          W          = 32,
   parameter logic [W-1:0]         ST_MASK    = '1,
   parameter int unsigned          MASTER_BIT = 31,
   parameter bit                   OUT_REG    = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] en,
   input  logic [W-1:0] st,
   output logic         irq
);

   logic pend;

   always_comb pend = en[MASTER_BIT] & (|(en & st & ST_MASK));

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= pend;
         end
      end else begin : g_comb
         always_comb irq = pend;
      end
   endgenerate

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
   import irq_gate_pkg::*;
#(
   parameter logic [REG_W-1:0] EVT_MASK   = 32'h4000_007F,
   parameter int unsigned      MASTER_BIT = 31,
   parameter bit               OUT_REG    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_addr,
   input  logic [REG_W-1:0] wr_data,
   input  logic [SEL_W-1:0] rd_addr,
   output logic [REG_W-1:0] rd_data,
   input  logic [REG_W-1:0] evt_i,
   output logic             irq_o
);

   localparam logic [REG_W-1:0] EN_MASK = en_mask_f(EVT_MASK, MASTER_BIT);
   localparam logic [REG_W-1:0] ST_MASK = st_mask_f(EVT_MASK, MASTER_BIT);

   generate
      if (MASTER_BIT >= REG_W) begin : g_bad_master
         $error("MASTER_BIT outside the register word");
      end
      if (EVT_MASK[MASTER_BIT]) begin : g_bad_overlap
         $error("EVT_MASK must not include the master position");
      end
      if (ST_MASK == '0) begin : g_bad_empty
         $error("EVT_MASK selects no event");
      end
   endgenerate

   reg_sel_e         wsel;
   reg_sel_e         rsel;
   logic             set_we;
   logic             clr_we;
   logic             ack_we;
   logic [REG_W-1:0] en_q;
   logic [REG_W-1:0] st_q;

   always_comb begin
      wsel   = reg_sel_e'(wr_addr);
      rsel   = reg_sel_e'(rd_addr);
      set_we = wr_en && (wsel == SEL_EN_SET);
      clr_we = wr_en && (wsel == SEL_EN_CLR);
      ack_we = wr_en && (wsel == SEL_STATUS);
   end

   irq_en_bank #(.W(REG_W), .MASK(EN_MASK)) u_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (set_we),
      .clr_we (clr_we),
      .wdata  (wr_data),
      .en_q   (en_q)
   );

   irq_evt_latch #(.W(REG_W), .MASK(ST_MASK)) u_st (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt_i),
      .ack_we (ack_we),
      .wdata  (wr_data),
      .st_q   (st_q)
   );

   irq_req_gen #(.W(REG_W), .ST_MASK(ST_MASK), .MASTER_BIT(MASTER_BIT),
                 .OUT_REG(OUT_REG)) u_req (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en_q),
      .st    (st_q),
      .irq   (irq_o)
   );

   always_comb begin
      unique case (rsel)
         SEL_STATUS:             rd_data = st_q;
         SEL_EN_SET, SEL_EN_CLR: rd_data = en_q;
         default:                rd_data = '0;
      endcase
   end

endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk
   import irq_gate_pkg::*;
#(
   parameter logic [REG_W-1:0] EVT_MASK   = 32'h4000_007F,
   parameter int unsigned      MASTER_BIT = 31
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [SEL_W-1:0] wr_addr,
   input logic [REG_W-1:0] wr_data,
   input logic [REG_W-1:0] evt_i,
   input logic [REG_W-1:0] en_q,
   input logic [REG_W-1:0] st_q,
   input logic             irq_o
);

   localparam logic [REG_W-1:0] EN_M = en_mask_f(EVT_MASK, MASTER_BIT);
   localparam logic [REG_W-1:0] ST_M = st_mask_f(EVT_MASK, MASTER_BIT);

   AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd1) |=> ((en_q & $past(wr_data & EN_M)) == $past(wr_data & EN_M))); // R2

   AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd2) |=> ((en_q & $past(wr_data & EN_M)) == '0)); // R3

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_q & ~EN_M) == '0) && ((st_q & ~ST_M) == '0)); // R4

   AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_i & ST_M)) |=> ((st_q & $past(evt_i & ST_M)) == $past(evt_i & ST_M))); // R8

   AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[MASTER_BIT] && |(en_q & st_q & ST_M)) |=> irq_o); // R9

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_q[MASTER_BIT] && |(en_q & st_q & ST_M)) |=> !irq_o); // R10

endmodule

bind irq_gate_ctrl irq_gate_chk #(.EVT_MASK(EVT_MASK), .MASTER_BIT(MASTER_BIT)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .evt_i   (evt_i),
   .en_q    (en_q),
   .st_q    (st_q),
   .irq_o   (irq_o)
);

// File: tb/tb_irq_gate_ctrl.sv
module tb_irq_gate_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] EN_MASK = 32'hC000_007F;
   localparam logic [31:0] ST_MASK = 32'h4000_007F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [31:0] evt_i = '0;
   logic        irq_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] en_m = '0;
   logic [31:0] st_m = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_gate_ctrl dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .evt_i(evt_i), .irq_o(irq_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one clock: inputs driven at a falling edge, results sampled at the next one
   task automatic tick(input logic we, input logic [1:0] a, input logic [31:0] d,
                       input logic [31:0] ev);
      logic gate;
      gate = en_m[31] && (|(en_m & st_m & ST_MASK));
      wr_en = we; wr_addr = a; wr_data = d; evt_i = ev;
      if (we && a == 2'd1) en_m = en_m | (d & EN_MASK);
      if (we && a == 2'd2) en_m = en_m & ~(d & EN_MASK);
      if (we && a == 2'd0) st_m = st_m & ~(d & ST_MASK);
      st_m = st_m | (ev & ST_MASK);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; evt_i = '0;
      check(gate ? "R9 irq raised" : "R10 irq held low", {31'd0, irq_o}, {31'd0, gate});
   endtask

   task automatic rd(input string tag, input logic [1:0] a, input logic [31:0] exp);
      rd_addr = a;
      #1;
      check(tag, rd_data, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd("R1 status", 2'd0, 32'h0);
      rd("R1 enable", 2'd1, 32'h0);
      check("R1 irq", {31'd0, irq_o}, 32'h0);

      // R2 R4 R5 walk a one through the set port
      for (int i = 0; i < 32; i++) begin
         tick(1'b1, 2'd1, 32'h1 << i, '0);
         rd("R2 R4 set read", 2'd1, en_m);
         rd("R5 clr port mirrors", 2'd2, en_m);
      end
      check("R2 all impl set", en_m, EN_MASK);
      tick(1'b1, 2'd1, 32'h0, '0);
      rd("R2 zero write keeps", 2'd1, EN_MASK);

      // R3 walk a one through the clear port
      for (int i = 0; i < 32; i++) begin
         tick(1'b1, 2'd2, 32'h1 << i, '0);
         rd("R3 clr read", 2'd2, en_m);
      end
      rd("R3 all cleared", 2'd1, 32'h0);

      // R5 unused address
      tick(1'b1, 2'd3, 32'hFFFF_FFFF, 32'h0);
      rd("R5 addr3 reads zero", 2'd3, 32'h0);
      rd("R5 addr3 write no enable", 2'd1, 32'h0);
      rd("R5 addr3 write no status", 2'd0, 32'h0);

      // R6 R7 R4 walk event pulses and acknowledges
      for (int i = 0; i < 32; i++) begin
         tick(1'b0, 2'd0, '0, 32'h1 << i);
         rd("R6 R4 event latch", 2'd0, st_m);
         tick(1'b1, 2'd0, 32'h0, '0);
         rd("R7 zero ack keeps", 2'd0, st_m);
         tick(1'b1, 2'd0, 32'h1 << i, '0);
         rd("R7 ack clears", 2'd0, 32'h0);
      end

      // R8 set beats clear
      tick(1'b0, 2'd0, '0, 32'h0000_0005);
      tick(1'b1, 2'd0, 32'h0000_0005, 32'h0000_0001);
      rd("R8 set wins", 2'd0, 32'h0000_0001);
      tick(1'b1, 2'd0, 32'hFFFF_FFFF, '0);
      rd("R8 cleanup", 2'd0, 32'h0);

      // R9 R10 gating per status position
      for (int i = 0; i < 32; i++) begin
         if (ST_MASK[i]) begin
            tick(1'b1, 2'd1, 32'h8000_0000, '0);     // master only
            tick(1'b0, 2'd0, '0, '0);
            tick(1'b1, 2'd2, 32'h8000_0000, '0);
            tick(1'b1, 2'd1, 32'h1 << i, 32'h1 << i); // pair, no master
            tick(1'b0, 2'd0, '0, '0);
            tick(1'b1, 2'd1, 32'h8000_0000, '0);     // master joins
            tick(1'b0, 2'd0, '0, '0);
            check("R9 raised after master", {31'd0, irq_o}, 32'h1);
            tick(1'b1, 2'd0, 32'h1 << i, '0);         // acknowledge
            tick(1'b0, 2'd0, '0, '0);
            check("R10 dropped after ack", {31'd0, irq_o}, 32'h0);
            tick(1'b1, 2'd2, EN_MASK, '0);
         end
      end
      // R10 mismatched pair
      tick(1'b1, 2'd1, 32'h8000_0001, 32'h0000_0002);
      tick(1'b0, 2'd0, '0, '0);
      check("R10 mismatch low", {31'd0, irq_o}, 32'h0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule